// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block produces the SCL clock for an I2C master. A free-running divider turns the system clock into a reference tick at the system rate divided by a power of two, which a 3-bit select value chooses. Two 5-bit period values set how many reference ticks the low and high halves of each SCL period last. Each half is also lengthened by a fixed number of ticks. That overhead is 4 ticks when the divider is bypassed (select 0) and 3 ticks for any other select value.

The block drives SCL low through an open-drain style output during the low half and releases it for the high half. It watches the real bus line through a two-stage synchroniser and a one-cycle glitch filter. The high half is only counted while the filtered line reads high, so a slave that holds SCL low stretches the clock. New period and divider settings are taken in only at phase boundaries, so a phase never ends early. Two one-cycle strobes mark the start of each low and high half for the byte engine.

Top module: `i2c_scl_rate_gen`

## Requirements
- R1: After reset, scl_pull_low, low_begin and high_begin are all 0.
- R2: When run is sampled high while the block is idle, the next cycle shows scl_pull_low=1 together with a one-cycle low_begin pulse. scl_pull_low rises only in a cycle where low_begin is 1.
- R3: A low half lasts (max(low_per,1)+K)·2^div_sel clock cycles, where K=4 when div_sel=0 and K=3 otherwise.
- R4: A high half, measured from the cycle the bus line is first seen high until scl_pull_low rises again, lasts 4+(max(high_per,1)+K)·2^div_sel cycles. The 4 is the latency of the synchroniser and filter.
- R5: A period value of 0 behaves exactly like a value of 1.
- R6: While a slave holds SCL low after release, the high half does not advance. Its full length then equals the hold time plus the R4 length.
- R7: A low pulse of exactly one clock cycle on scl_in during the high half is ignored, and the high-half length stays as in R4.
- R8: A change of low_per, high_per or div_sel during a phase does not alter that phase. The new value applies from the next phase that starts.
- R9: high_begin is a one-cycle pulse in the first cycle of the high half, with scl_pull_low=0. It is never 1 in the same cycle as low_begin.
- R10: When run is sampled low, the next cycle shows scl_pull_low=0 and both strobes 0, and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Generate SCL while high; idle with SCL released while low |
| div_sel | input | 3 | Reference tick is clk divided by 2^div_sel |
| low_per | input | 5 | Low-half period value in reference ticks |
| high_per | input | 5 | High-half period value in reference ticks |
| scl_in | input | 1 | Sampled level of the SCL bus line |
| scl_pull_low | output | 1 | 1 = drive SCL low, 0 = release |
| low_begin | output | 1 | One-cycle strobe at the start of each low half |
| high_begin | output | 1 | One-cycle strobe at the start of each high half |

## Verification
The bench measures phase lengths in clock cycles over random divider and period settings. It catches an overhead that ignores the bypass case or a divider that is off by one tick. It uses period value 0 at several divider settings, which finds a design that runs a 0-length phase instead of clamping it to 1. It holds SCL low after release, and applies a one-cycle low pulse in the high half. The first catches a counter that runs before the line is high. The second catches a missing glitch filter, which would restart the count. It also changes the periods in the middle of a phase, which exposes a design that applies them at once and cuts the current phase short.

// File: rtl/i2c_scl_rate_pkg.sv
package i2c_scl_rate_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

endpackage

// File: rtl/i2c_scl_rate_div.sv
// Power-of-two reference tick divider with synchronous clear and gated advance.
module i2c_scl_rate_div #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [SEL_W-1:0] sel,
    output logic             tick_raw
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(sel));
        end
        tick_raw = (cnt_q == mask);
        cnt_d    = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (advance) begin
            cnt_d = tick_raw ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/i2c_scl_rate_filt.sv
// Two-stage synchroniser followed by a filter that needs two equal samples.
module i2c_scl_rate_filt #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_filt
);
    typedef struct packed {
        logic s0;
        logic s1;
        logic prev;
        logic filt;
    } filt_t;

    filt_t d, q;

    always_comb begin
        d      = q;
        d.s0   = line_in;
        d.s1   = q.s0;
        d.prev = q.s1;
        if (q.s1 == q.prev) begin
            d.filt = q.s1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{s0: RST_VAL, s1: RST_VAL, prev: RST_VAL, filt: RST_VAL};
        end else begin
            q <= d;
        end
    end

    assign line_filt = q.filt;

endmodule

// File: rtl/i2c_scl_rate_gen.sv
module i2c_scl_rate_gen
    import i2c_scl_rate_pkg::*;
#(
    parameter int SEL_W      = 3,
    parameter int PER_W      = 5,
    parameter int OVH_BYPASS = 4,
    parameter int OVH_DIV    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] div_sel,
    input  logic [PER_W-1:0] low_per,
    input  logic [PER_W-1:0] high_per,
    input  logic             scl_in,
    output logic             scl_pull_low,
    output logic             low_begin,
    output logic             high_begin
);
    localparam int MAX_OVH = (OVH_BYPASS > OVH_DIV) ? OVH_BYPASS : OVH_DIV;
    localparam int LEN_W   = $clog2((1 << PER_W) + MAX_OVH);

    typedef struct packed {
        phase_e             phase;
        logic [LEN_W-1:0]   cnt;
        logic [LEN_W-1:0]   len;
        logic [SEL_W-1:0]   sel;
        logic               lo_stb;
        logic               hi_stb;
    } gen_t;

    gen_t d, q;
    logic counting;
    logic div_clear;
    logic div_tick;
    logic tick;
    logic last;
    logic scl_filt;

    function automatic logic [LEN_W-1:0] phase_len(input logic [PER_W-1:0] per,
                                                   input logic [SEL_W-1:0] s);
        logic [LEN_W-1:0] p;
        p = (per == '0) ? LEN_W'(1) : LEN_W'(per);
        return p + ((s == '0) ? LEN_W'(OVH_BYPASS) : LEN_W'(OVH_DIV));
    endfunction

    i2c_scl_rate_filt #(.RST_VAL(1'b1)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (scl_in),
        .line_filt (scl_filt)
    );

    i2c_scl_rate_div #(.SEL_W(SEL_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (div_clear),
        .advance  (counting),
        .sel      (q.sel),
        .tick_raw (div_tick)
    );

    always_comb begin
        d         = q;
        d.lo_stb  = 1'b0;
        d.hi_stb  = 1'b0;
        counting  = 1'b0;
        div_clear = 1'b0;
        tick      = 1'b0;
        last      = (q.cnt == q.len - 1'b1);
        unique case (q.phase)
            PH_IDLE: begin
                div_clear = 1'b1;
                if (run) begin
                    d.phase  = PH_LOW;
                    d.cnt    = '0;
                    d.len    = phase_len(low_per, div_sel);
                    d.sel    = div_sel;
                    d.lo_stb = 1'b1;
                end
            end
            PH_LOW: begin
                counting = 1'b1;
                tick     = div_tick;
                if (tick) begin
                    if (last) begin
                        d.phase   = PH_HIGH;
                        d.cnt     = '0;
                        d.len     = phase_len(high_per, div_sel);
                        d.sel     = div_sel;
                        d.hi_stb  = 1'b1;
                        div_clear = 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            PH_HIGH: begin
                if (!scl_filt) begin
                    d.cnt     = '0;
                    div_clear = 1'b1;
                end else begin
                    counting = 1'b1;
                    tick     = div_tick;
                    if (tick) begin
                        if (last) begin
                            d.phase   = PH_LOW;
                            d.cnt     = '0;
                            d.len     = phase_len(low_per, div_sel);
                            d.sel     = div_sel;
                            d.lo_stb  = 1'b1;
                            div_clear = 1'b1;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
            end
            default: begin
                d.phase = PH_IDLE;
            end
        endcase
        if (!run) begin
            d.phase   = PH_IDLE;
            d.cnt     = '0;
            d.lo_stb  = 1'b0;
            d.hi_stb  = 1'b0;
            div_clear = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, cnt: '0, len: '0, sel: '0, lo_stb: 1'b0, hi_stb: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign scl_pull_low = (q.phase == PH_LOW);
    assign low_begin    = q.lo_stb;
    assign high_begin   = q.hi_stb;

endmodule

// File: rtl/i2c_scl_rate_chk.sv
module i2c_scl_rate_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic scl_pull_low,
    input logic low_begin,
    input logic high_begin
);

    a_r9_stb_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({low_begin, high_begin}));

    a_r2_low_begin_pulls: assert property (@(posedge clk) disable iff (!rst_n)
        low_begin |-> scl_pull_low);

    a_r2_pull_only_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_low) |-> low_begin);

    a_r9_high_begin_releases: assert property (@(posedge clk) disable iff (!rst_n)
        high_begin |-> !scl_pull_low);

    a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!scl_pull_low && !low_begin && !high_begin));

    a_r3_low_not_single: assert property (@(posedge clk) disable iff (!rst_n)
        (low_begin && run) |=> scl_pull_low);

endmodule

bind i2c_scl_rate_gen i2c_scl_rate_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run),
    .scl_pull_low (scl_pull_low),
    .low_begin    (low_begin),
    .high_begin   (high_begin)
);

// File: tb/i2c_scl_rate_gen_bench.sv
module i2c_scl_rate_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       hold = 1'b0;
    logic [2:0] sel = 3'd0;
    logic [4:0] lo = 5'd5;
    logic [4:0] hi = 5'd5;
    logic       scl_in;
    logic       scl_pull_low, low_begin, high_begin;

    assign scl_in = ~(scl_pull_low | hold);

    i2c_scl_rate_gen u_i2c_scl_rate_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .div_sel      (sel),
        .low_per      (lo),
        .high_per     (hi),
        .scl_in       (scl_in),
        .scl_pull_low (scl_pull_low),
        .low_begin    (low_begin),
        .high_begin   (high_begin)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int  low_cnt = 0, high_cnt = 0;
    int  low_len = 0, high_len = 0, high_total = 0;
    int  t_low = 0, t_rel = 0, t_rise = 0;
    bit  rel_seen = 0, rise_seen = 0, pull_prev = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // phase length monitor, sampled 3 ns after each rising edge
    always begin
        @(posedge clk);
        #3;
        if (scl_pull_low && !pull_prev) begin
            if (rel_seen) begin
                high_len   = cyc - t_rise;
                high_total = cyc - t_rel;
                high_cnt++;
            end
            t_low    = cyc;
            rel_seen = 1'b0;
        end
        if (!scl_pull_low && pull_prev) begin
            low_len   = cyc - t_low;
            low_cnt++;
            t_rel     = cyc;
            rel_seen  = 1'b1;
            rise_seen = 1'b0;
        end
        if (rel_seen && !rise_seen && scl_in) begin
            t_rise    = cyc;
            rise_seen = 1'b1;
        end
        pull_prev = scl_pull_low;
    end

    function automatic int ovh(int n);
        return (n == 0) ? 4 : 3;
    endfunction
    function automatic int eff(int p);
        return (p == 0) ? 1 : p;
    endfunction
    function automatic int exp_low(int l, int n);
        return (eff(l) + ovh(n)) << n;
    endfunction
    function automatic int exp_high(int h, int n);
        return 4 + ((eff(h) + ovh(n)) << n);
    endfunction

    task automatic step(int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_low_done(int k);
        int t;
        t = low_cnt + k;
        while (low_cnt < t) step(1);
    endtask

    task automatic wait_high_done();
        int t;
        t = high_cnt + 1;
        while (high_cnt < t) step(1);
    endtask

    task automatic wait_lb();
        step(1);
        while (!low_begin) step(1);
    endtask

    task automatic wait_hb();
        step(1);
        while (!high_begin) step(1);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    task automatic stretch(int s, int h, int n);
        wait_lb();
        hold = 1'b1;
        wait_hb();
        step(s);
        hold = 1'b0;
        wait_high_done();
        check("R6 high from rise", high_len, exp_high(h, n));
        check("R6 high with stretch", high_total, s + exp_high(h, n));
    endtask

    initial begin
        void'($urandom(32'd24681357));
        step(3);
        check("R1 reset pull", int'(scl_pull_low), 0);
        check("R1 reset strobes", int'(low_begin | high_begin), 0);
        rst_n = 1'b1;
        step(3);
        check("R1 idle pull", int'(scl_pull_low), 0);

        // R2 start
        sel = 3'd0; lo = 5'd5; hi = 5'd6;
        run = 1'b1;
        step(1);
        check("R2 pull at start", int'(scl_pull_low), 1);
        check("R2 low_begin at start", int'(low_begin), 1);
        step(1);
        check("R2 low_begin one cycle", int'(low_begin), 0);
        wait_low_done(2);
        check("R3 low div0", low_len, exp_low(5, 0));
        check("R4 high div0", high_len, exp_high(6, 0));

        // R3/R4 random settings
        for (int i = 0; i < 16; i++) begin
            sel = 3'($urandom_range(0, 4));
            lo  = 5'($urandom_range(0, 31));
            hi  = 5'($urandom_range(0, 31));
            wait_low_done(2);
            check("R3 low random", low_len, exp_low(int'(lo), int'(sel)));
            check("R4 high random", high_len, exp_high(int'(hi), int'(sel)));
        end
        sel = 3'd7; lo = 5'd1; hi = 5'd2;
        wait_low_done(2);
        check("R3 low div7", low_len, exp_low(1, 7));
        check("R4 high div7", high_len, exp_high(2, 7));

        // R5 zero periods
        sel = 3'd0; lo = 5'd0; hi = 5'd0;
        wait_low_done(2);
        check("R5 low zero div0", low_len, exp_low(1, 0));
        check("R5 high zero div0", high_len, exp_high(1, 0));
        sel = 3'd2;
        wait_low_done(2);
        check("R5 low zero div2", low_len, exp_low(1, 2));
        check("R5 high zero div2", high_len, exp_high(1, 2));

        // R8 mid-phase changes
        sel = 3'd0; lo = 5'd8; hi = 5'd4;
        wait_low_done(2);
        wait_lb();
        step(3);
        lo = 5'd20;
        wait_low_done(1);
        check("R8 low keeps old", low_len, exp_low(8, 0));
        wait_low_done(1);
        check("R8 low takes new", low_len, exp_low(20, 0));
        wait_hb();
        step(2);
        hi = 5'd12;
        wait_high_done();
        check("R8 high keeps old", high_len, exp_high(4, 0));
        wait_high_done();
        check("R8 high takes new", high_len, exp_high(12, 0));

        // R6 slave stretching
        sel = 3'd1; lo = 5'd3; hi = 5'd3;
        wait_low_done(2);
        stretch(15, 3, 1);
        sel = 3'd0;
        wait_low_done(2);
        stretch(7, 3, 0);

        // R7 one-cycle glitch in high half
        sel = 3'd0; lo = 5'd4; hi = 5'd10;
        wait_low_done(2);
        wait_hb();
        step(8);
        hold = 1'b1;
        step(1);
        hold = 1'b0;
        wait_high_done();
        check("R7 glitch ignored", high_len, exp_high(10, 0));
        check("R7 glitch total", high_total, exp_high(10, 0));

        // R9 high strobe
        wait_hb();
        check("R9 released at high_begin", int'(scl_pull_low), 0);
        check("R9 no low_begin with high_begin", int'(low_begin), 0);
        step(1);
        check("R9 high_begin one cycle", int'(high_begin), 0);

        // R10 stop
        wait_lb();
        step(2);
        run = 1'b0;
        step(1);
        check("R10 released after stop", int'(scl_pull_low), 0);
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 40; k++) begin
                step(1);
                if (scl_pull_low || low_begin || high_begin) seen++;
            end
            check("R10 stays idle", seen, 0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            summary();
            $finish;
        end
    end

endmodule